// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block multiplies two 32-bit operands into a full 64-bit product. It treats the operands as either unsigned or two's complement integers. It can also add the product to a 64-bit accumulator value. The accumulator arrives as two 32-bit words, an upper and a lower one, and the result leaves the same way. The caller writes the result back over the accumulator pair.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream. A single register stage sits between them. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result shows on the outputs from the next cycle. The result stays there unchanged until the consumer takes it with `out_valid` and `out_ready` both high at an edge. `in_ready` is high while the output register is empty or is being drained in that same cycle. A request may therefore be accepted in every cycle while `out_ready` stays high.

Top module: `lmac_unit`

## Requirements
- R1: With `in_op` = 2'b00, both operands are treated as unsigned and the result is their exact 64-bit product. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R2: With `in_op` = 2'b10, both operands are treated as two's complement and the result is the 64-bit two's complement product. 0xFFFFFFFF times 0xFFFFFFFF gives 1, and 0x80000000 squared gives 0x4000000000000000.
- R3: With `in_op` = 2'b01, the result is the unsigned product plus {`in_acc_hi`,`in_acc_lo`}, taken modulo 2^64. A sum that passes 2^64 wraps, and no carry is reported.
- R4: With `in_op` = 2'b11, the result is the signed product plus the signed value {`in_acc_hi`,`in_acc_lo`}, taken modulo 2^64.
- R5: When `in_op` bit 0 is 0, the accumulator inputs have no effect on the result.
- R6: A request accepted at a rising edge makes `out_valid` high from that edge on, with its result on the outputs. `out_valid` never rises without an accepted request.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and the result words and `out_valid` hold their values.
- R8: A synchronous reset (`rst` high at an edge) clears `out_valid`. After reset `in_ready` is high.
- R9: `out_lo` carries result bits 31:0 and `out_hi` carries bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 2 | Bit 0: accumulate, bit 1: signed |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_acc_hi | input | 32 | Accumulator bits 63:32 |
| in_acc_lo | input | 32 | Accumulator bits 31:0 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hi | output | 32 | Result bits 63:32 |
| out_lo | output | 32 | Result bits 31:0 |

## Verification
The assertions check the stream rules on every cycle. They cover reset clearing of the output flag, the one-cycle delay from acceptance to a valid result, and the absence of spurious results. They also check that the result holds and `in_ready` drops while the consumer stalls. The arithmetic can only be shown by the bench's scenarios. These compare every cycle against a behavioural model across all four opcodes and the listed corner products, including an accumulate that wraps past 2^64. They also drive nonzero accumulator values in the plain multiply modes, where those values must be ignored.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [1:0] {
    OP_UMUL = 2'b00,
    OP_UMAC = 2'b01,
    OP_SMUL = 2'b10,
    OP_SMAC = 2'b11
  } lmac_op_e;

  function automatic logic op_accumulates(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_signed(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/lmac_operand_ext.sv
// Widens an operand to the full result width, by sign or by zero.
module lmac_operand_ext #(
  parameter int W = 32
) (
  input  logic [W-1:0]   val,
  input  logic           is_signed,
  output logic [2*W-1:0] wide
);
  logic fill;
  always_comb begin
    fill = is_signed & val[W-1];
    wide = {{W{fill}}, val};
  end
endmodule

// File: rtl/lmac_mul.sv
// Product of two widened operands, kept modulo 2^(2W). The result is exact
// for both signed and unsigned inputs.
module lmac_mul #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] a_wide,
  input  logic [2*W-1:0] b_wide,
  output logic [2*W-1:0] prod
);
  always_comb prod = a_wide * b_wide;
endmodule

// File: rtl/lmac_acc_add.sv
// Optional add of the accumulator pair, wrapping modulo 2^(2W).
module lmac_acc_add #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           acc_en,
  input  logic [W-1:0]   acc_hi,
  input  logic [W-1:0]   acc_lo,
  output logic [2*W-1:0] sum
);
  logic [2*W-1:0] addend;
  always_comb begin
    addend = acc_en ? {acc_hi, acc_lo} : '0;
    sum    = prod + addend;
  end
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_acc_hi,
  input  logic [W-1:0] in_acc_lo,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_hi,
  output logic [W-1:0] out_lo
);
  import lmac_pkg::*;

  localparam int RW = 2 * W;

  logic [W-1:0]  opnd   [2];
  logic [RW-1:0] widened[2];
  logic [RW-1:0] prod;
  logic [RW-1:0] sum;
  logic          sgn;
  logic          acc_en;
  logic          take;
  logic [RW-1:0] res_q;
  logic          vld_q;

  assign sgn     = op_signed(in_op);
  assign acc_en  = op_accumulates(in_op);
  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    lmac_operand_ext #(.W(W)) u_ext (
      .val      (opnd[g]),
      .is_signed(sgn),
      .wide     (widened[g])
    );
  end

  lmac_mul #(.W(W)) u_mul (
    .a_wide(widened[0]),
    .b_wide(widened[1]),
    .prod  (prod)
  );

  lmac_acc_add #(.W(W)) u_add (
    .prod  (prod),
    .acc_en(acc_en),
    .acc_hi(in_acc_hi),
    .acc_lo(in_acc_lo),
    .sum   (sum)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) res_q <= sum;
  end

  assign out_valid = vld_q;
  assign out_lo    = res_q[W-1:0];
  assign out_hi    = res_q[RW-1:W];
endmodule

// File: rtl/lmac_unit_chk.sv
module lmac_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_hi,
  input logic [W-1:0] out_lo
);
  a_r8_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  a_r6_accept_gives_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hi) && $stable(out_lo)));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind lmac_unit lmac_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_hi   (out_hi),
  .out_lo   (out_lo)
);

// File: tb/test_lmac_unit.sv
module test_lmac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0, in_b = '0, in_acc_hi = '0, in_acc_lo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_hi, out_lo;

  int total = 0;
  int bad = 0;
  int bp_mode = 0;
  int cyc = 0;

  // behavioural model state
  bit          m_vld = 0;
  logic [63:0] m_res = '0;
  logic [1:0]  m_op = '0;

  always #2.5 clk = ~clk;

  lmac_unit i_lmac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_acc_hi(in_acc_hi),
    .in_acc_lo(in_acc_lo), .out_valid(out_valid), .out_ready(out_ready),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  function automatic logic [63:0] expect_of(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                            logic [31:0] hi, logic [31:0] lo);
    logic [63:0] p;
    longint sp;
    if (op[1]) begin
      sp = longint'($signed(a)) * longint'($signed(b));
      p  = 64'(sp);
    end else begin
      p = 64'(a) * 64'(b);
    end
    if (op[0]) p = p + {hi, lo};
    return p;
  endfunction

  function automatic string tag_of(logic [1:0] op);
    case (op)
      2'b00:   return "R1/R5/R9";
      2'b10:   return "R2/R5/R9";
      2'b01:   return "R3/R9";
      default: return "R4/R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // back-pressure pattern
  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3) != 0;
      default: out_ready <= (cyc % 5) == 0;
    endcase
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      check("R6 out_valid", 64'(out_valid), 64'(m_vld));
      check("R7 in_ready", 64'(in_ready), 64'(!m_vld || out_ready));
      if (m_vld) check(tag_of(m_op), {out_hi, out_lo}, m_res);
    end
    // model update for the coming edge
    if (rst) m_vld = 0;
    else if (in_valid && (!m_vld || out_ready)) begin
      m_vld = 1;
      m_res = expect_of(in_op, in_a, in_b, in_acc_hi, in_acc_lo);
      m_op  = in_op;
    end else if (out_ready) m_vld = 0;
  end

  task automatic send(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                      logic [31:0] hi, logic [31:0] lo);
    bit done = 0;
    @(negedge clk);
    in_valid = 1; in_op = op; in_a = a; in_b = b; in_acc_hi = hi; in_acc_lo = lo;
    while (!done) begin
      #3;
      if (in_ready) done = 1;
      else @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #3;
    check("R8 reset out_valid", 64'(out_valid), 64'd0);
    check("R8 reset in_ready", 64'(in_ready), 64'd1);

    // R1, R2: corner products; R5: accumulator garbage must be ignored
    send(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hDEADBEEF, 32'h12345678);
    send(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hCAFEF00D, 32'h0BADF00D);
    send(2'b10, 32'h80000000, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF);
    send(2'b10, 32'h80000000, 32'h00000001, 32'h0, 32'h0);
    send(2'b00, 32'h80000000, 32'h80000000, 32'h1, 32'h1);
    // R3: wrap past 2^64
    send(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF);
    send(2'b01, 32'h00010000, 32'h00010000, 32'hFFFFFFFF, 32'h00000000);
    // R4: signed accumulate, negative addend and wrap
    send(2'b11, 32'hFFFFFFFE, 32'h00000003, 32'h00000000, 32'h00000006);
    send(2'b11, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFF);
    send(2'b11, 32'h80000000, 32'h80000000, 32'hC0000000, 32'h00000000);
    idle();
    repeat (3) @(negedge clk);

    // R7: stalls under back-pressure
    for (int m = 1; m <= 2; m++) begin
      bp_mode = m;
      for (int i = 0; i < 24; i++)
        send(2'(i), 32'h9E3779B9 * (i + 1), 32'h7F4A7C15 ^ (i * 32'h01010101),
             32'hA5A5A5A5 + i, 32'h3C3C3C3C * i);
      idle();
      repeat (12) @(negedge clk);
    end
    bp_mode = 0;

    // R8: reset with a result pending
    bp_mode = 2;
    send(2'b00, 32'd7, 32'd9, 32'd0, 32'd0);
    idle();
    rst = 1;
    @(negedge clk);
    rst = 0;
    #3;
    check("R8 reset clears pending out_valid", 64'(out_valid), 64'd0);
    bp_mode = 0;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule